// File: doc/BRIEF.md
# Four-Bit Mode-Steered Shift Register

This block holds a small word in a chain of stages and either moves it one place toward the tail, taking a new bit in at the head, or overwrites every stage at once from a parallel input. A single mode bit picks which of the two operations may happen. Each operation has its own single-cycle strobe, and both strobes are sampled on the rising edge of one system clock. A strobe that does not match the current mode is ignored.

The block covers four usage patterns. It can take bits in serially and present the whole word, or pass bits through the chain so that they leave at the tail after a delay. It can also capture a word in parallel and then stream it out at the tail, or simply act as a parallel latch. All stage outputs are visible, and the tail stage is also the serial output.

Top module: `mshift_top`

## Requirements
- R1: A synchronous active-high reset sets every stage, and therefore the serial output, to 0 at the next rising clock edge.
- R2: With the mode bit at 1, a load strobe copies par_in into the stages on the next edge. Bit 0 of par_in goes to the head stage (q_out[0]) and the top bit goes to the tail stage.
- R3: With the mode bit at 0, a shift strobe moves the word one stage toward the tail. ser_in enters q_out[0], and each q_out[i] takes the old q_out[i-1].
- R4: The serial output ser_out always equals the tail stage q_out[WIDTH-1].
- R5: After WIDTH shift strobes in shift mode, the first bit entered is at ser_out. Each further strobe presents the next bit in the order it was entered.
- R6: A word loaded in load mode, followed by a switch to shift mode, leaves at ser_out one bit per shift strobe, tail bit first. Zeros follow it when ser_in is 0.
- R7: A shift strobe in load mode and a load strobe in shift mode leave all stages unchanged.
- R8: When both strobes are high in the same cycle, only the strobe that matches the mode takes effect.
- R9: With no valid strobe in a cycle, the stages hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 1 = load mode, 0 = shift mode |
| shift_stb | input | 1 | Single-cycle shift strobe |
| load_stb | input | 1 | Single-cycle load strobe |
| ser_in | input | 1 | Serial data bit entering the head stage |
| par_in | input | WIDTH | Parallel word; bit 0 goes to the head stage |
| q_out | output | WIDTH | All stage values; bit 0 is the head |
| ser_out | output | 1 | Tail stage, used as the serial output |

## Verification
The assertions check the single-step behaviour on every cycle: the result of a load, the result of a shift, holding when no strobe is honoured, and the tail tap. Multi-step orderings need the bench's scenarios, because they are only visible across many strobes compared against a reference queue. These are bits emerging WIDTH strobes after entry, a loaded word streaming out tail first, and pass-through of long serial streams.

// File: rtl/mshift_pkg.sv
package mshift_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } op_e;

  function automatic op_e pick_op(input logic mode, input logic sh, input logic ld);
    if (mode && ld)       return OP_LOAD;
    else if (!mode && sh) return OP_SHIFT;
    else                  return OP_HOLD;
  endfunction
endpackage

// File: rtl/mshift_ctrl.sv
module mshift_ctrl
  import mshift_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic shift_stb,
  input  logic load_stb,
  output op_e  op
);
  assign op = pick_op(mode, shift_stb, load_stb);

  // R7
  mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode && !load_stb) || (!mode && !shift_stb)) |-> (op == OP_HOLD));
  // R8
  both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_stb && load_stb) |-> (op == (mode ? OP_LOAD : OP_SHIFT)));
endmodule

// File: rtl/mshift_stage.sv
module mshift_stage (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic load_en,
  input  logic prev_bit,
  input  logic par_bit,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (load_en)  q <= par_bit;
    else if (shift_en) q <= prev_bit;
  end
endmodule

// File: rtl/mshift_top.sv
module mshift_top
  import mshift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             shift_stb,
  input  logic             load_stb,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q_out,
  output logic             ser_out
);
  localparam int TAIL = WIDTH - 1;

  op_e             op;
  logic            do_shift;
  logic            do_load;
  logic [WIDTH-1:0] chain_in;

  mshift_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode(mode),
    .shift_stb(shift_stb), .load_stb(load_stb), .op(op)
  );

  assign do_shift = (op == OP_SHIFT);
  assign do_load  = (op == OP_LOAD);
  assign chain_in = {q_out[WIDTH-2:0], ser_in};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    mshift_stage u_st (
      .clk(clk), .rst(rst), .shift_en(do_shift), .load_en(do_load),
      .prev_bit(chain_in[i]), .par_bit(par_in[i]), .q(q_out[i])
    );
  end

  assign ser_out = q_out[TAIL];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q_out == '0));
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    do_load |=> (q_out == $past(par_in)));
  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    do_shift |=> (q_out == {$past(q_out[WIDTH-2:0]), $past(ser_in)}));
  // R9
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!do_shift && !do_load) |=> $stable(q_out));
  // R4
  tail_tap_chk: assert property (@(posedge clk) ser_out == q_out[TAIL]);
endmodule

// File: tb/test_mshift_top.sv
module test_mshift_top;
  localparam int W = 4;
  logic clk = 0, rst = 1, mode = 0, shift_stb = 0, load_stb = 0, ser_in = 0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q_out;
  logic ser_out;
  int checks = 0, errors = 0;
  logic [W-1:0] model = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mshift_top #(.WIDTH(W)) i_mshift_top (.*);

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic m, logic sh,
                                             logic ld, logic si, logic [W-1:0] p);
    if (m == 1'b1 && ld) return p;
    if (m == 1'b0 && sh) return (cur << 1) | {{(W-1){1'b0}}, si};
    return cur;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic m, logic sh, logic ld, logic si, logic [W-1:0] p, string req);
    mode = m; shift_stb = sh; load_stb = ld; ser_in = si; par_in = p;
    model = ref_next(model, m, sh, ld, si, p);
    @(posedge clk); #1;
    shift_stb = 0; load_stb = 0;
    chk(req, q_out, model);
    chk("R4", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, model[W-1]});
  endtask

  initial begin
    #5000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1; par_in = 4'hF;
    @(posedge clk); @(posedge clk); #1;
    chk("R1", q_out, '0);
    rst = 0; model = '0;

    // R3 / R5 serial in, bits entered 1,0,1,1; first bit reaches tail after W shifts
    begin
      logic [3:0] bits = 4'b1101;
      for (int i = 0; i < W; i++) step(0, 1, 0, bits[i], '0, "R3");
      chk("R5", {3'b0, ser_out}, {3'b0, bits[0]});
      step(0, 1, 0, 0, '0, "R5");
      chk("R5", {3'b0, ser_out}, {3'b0, bits[1]});
    end

    // R2 load, R6 stream out tail first
    step(1, 0, 1, 0, 4'b0110, "R2");
    for (int i = W - 1; i >= 0; i--) begin
      chk("R6", {3'b0, ser_out}, {3'b0, model[W-1]});
      chk("R6", {3'b0, ser_out}, {3'b0, logic'(4'b0110 >> i)});
      step(0, 1, 0, 0, '0, "R6");
    end
    chk("R6", q_out, '0);

    // R7 mismatched pairs
    step(1, 0, 1, 0, 4'b1001, "R2");
    step(1, 1, 0, 1, 4'b0000, "R7");
    chk("R7", q_out, 4'b1001);
    step(0, 0, 1, 0, 4'b0110, "R7");
    chk("R7", q_out, 4'b1001);

    // R8 both strobes
    step(1, 1, 1, 1, 4'b0011, "R8");
    chk("R8", q_out, 4'b0011);
    step(0, 1, 1, 1, 4'b1100, "R8");
    chk("R8", q_out, 4'b0111);

    // R9 idle hold
    step(0, 0, 0, 1, 4'b1111, "R9");
    step(1, 0, 0, 0, 4'b0000, "R9");

    // random mix against reference
    for (int n = 0; n < 400; n++) begin
      logic m, sh, ld, si;
      logic [W-1:0] p;
      m = 1'($urandom); sh = 1'($urandom); ld = 1'($urandom);
      si = 1'($urandom); p = W'($urandom);
      step(m, sh, ld, si, p, "R3");
      if (n % 97 == 0) begin
        rst = 1; @(posedge clk); #1; rst = 0; model = '0;
        chk("R1", q_out, '0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule